// File: doc/BRIEF.md
# Prescaled Period Timer with Latched-Duty PWM and Postscaled Interrupt

This block produces a pulse-width-modulated output from an 8-bit timer. Each timer step takes four input clocks, multiplied by a prescale factor of 1, 4 or 16. The timer counts up to a programmed period value and then restarts from zero, so the waveform repeats with no help from software. The duty value has 10 bits. Its upper 8 bits come from one field and its lower 2 bits from a second field. It is compared against the timer extended by a 2-bit sub-step count, which gives quarter-step resolution.

A new duty value is held in a buffer and takes effect only when the next period starts, so a host may rewrite it at any moment, including from its interrupt handler. Every period restart is a match event, and a postscaler counts these events. After a programmable number of matches (1 to 16) the postscaler sets a sticky flag. The host clears that flag with a one-clock strobe. The interrupt request is the flag gated by three enables: one for the timer, one for the peripheral group and one global.

All inputs are plain register-style levels, and the flag clear is a single-cycle strobe. The block has no streamed data path, so no valid/ready handshake exists. Back-pressure does not apply, because every output is a level that the host reads whenever it chooses.

Top module: `pwm_postscale_timer`

## Requirements
- R1: Prescale select `pre_sel_i` maps 2'b00 to ×1, 2'b01 to ×4, and 2'b10 or 2'b11 to ×16 (P). One PWM period lasts (period_i+1)×4×P clocks, and the timer restarts from zero when it steps while equal to period_i.
- R2: The duty D equals duty_hi_i×4+duty_lo_i. In PWM mode, the output is high for min(D, 4×(period_i+1))×P clocks at the start of each period and low for the rest of that period.
- R3: With D=0 the output stays low for the whole period. With D ≥ 4×(period_i+1) it stays high for the whole period.
- R4: A duty change made in the middle of a period leaves that period unchanged. The new value applies from the next period start.
- R5: The output is driven only when `mode_i` is 2'b11. Any other mode holds it low, while the timer and the postscaler keep running.
- R6: With `post_div_i`=N−1, `flag_o` rises once per N period matches. It becomes visible on the first clock of the period that follows the Nth match, counted from enable.
- R7: `flag_o` stays set until a `flag_clr_i` strobe clears it.
- R8: `irq_o` is high exactly when `flag_o`, `ie_tmr_i`, `ie_periph_i` and `ie_global_i` are all high.
- R9: While `tmr_on_i` is low, the timer and prescaler hold their values and `pwm_o` is low. Setting the bit again resumes the period at the point where it stopped.
- R10: While `tmr_on_i` is low, the postscaler match count is cleared.
- R11: After reset `pwm_o`, `flag_o` and `irq_o` are low, and the timer sits at the start of a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tmr_on_i | input | 1 | Timer run enable |
| pre_sel_i | input | 2 | Prescale select (×1, ×4, ×16) |
| post_div_i | input | 4 | Postscale ratio minus one |
| period_i | input | 8 | Period value (last timer count) |
| duty_hi_i | input | 8 | Duty, upper 8 bits |
| duty_lo_i | input | 2 | Duty, lower 2 bits |
| mode_i | input | 2 | Output mode; 2'b11 selects PWM |
| ie_tmr_i | input | 1 | Timer interrupt enable |
| ie_periph_i | input | 1 | Peripheral group interrupt enable |
| ie_global_i | input | 1 | Global interrupt enable |
| flag_clr_i | input | 1 | One-cycle flag clear strobe |
| pwm_o | output | 1 | PWM waveform |
| irq_o | output | 1 | Gated interrupt request |
| flag_o | output | 1 | Sticky match-interrupt flag |

## Verification
The bench sweeps every prescale code over small periods and every duty from zero to just past the full period. Each result is compared with the arithmetic high time and with the clock at which the first flag appears. A wrong prescale mapping or a missing quarter-step compare would show up as high counts off by a factor or by P. It rewrites the duty while the output is high and expects that period to keep its old width, which catches a design that loads the compare directly and cuts the pulse short. It pauses the timer partway through a period and expects the output to be low during the pause and the period to resume where it stopped. It also expects the postscaler to restart its count after the pause, so a design that keeps a stale count would raise the flag about one period early. Every combination of the three enables is checked against the interrupt output.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

  typedef enum logic [1:0] {
    PRE_X1    = 2'b00,
    PRE_X4    = 2'b01,
    PRE_X16   = 2'b10,
    PRE_X16_B = 2'b11
  } pre_sel_e;

  localparam logic [1:0] MODE_PWM = 2'b11;

  // log2 of the prescale factor for a select code
  function automatic logic [2:0] pre_shift(input logic [1:0] sel);
    logic [2:0] sh;
    case (pre_sel_e'(sel))
      PRE_X1:  sh = 3'd0;
      PRE_X4:  sh = 3'd2;
      default: sh = 3'd4;
    endcase
    return sh;
  endfunction

endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
  parameter int unsigned SUB_W = 2,
  parameter int unsigned PC_W  = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [1:0]       sel_i,
  output logic             tick_o,
  output logic [SUB_W-1:0] sub_o
);
  import pwm_timer_pkg::*;

  localparam logic [2:0] TOP_SH = 3'(PC_W - SUB_W);

  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_end;
  logic [2:0]      sh;

  always_comb begin
    sh     = pre_shift(sel_i);
    pc_end = {PC_W{1'b1}} >> (TOP_SH - sh);
    sub_o  = SUB_W'(pc_q >> sh);
    tick_o = run_i && (pc_q >= pc_end);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pc_q <= '0;
    else if (run_i) pc_q <= tick_o ? '0 : pc_q + 1'b1;
  end

  AST_PC_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(pc_q)); // R9

endmodule

// File: rtl/pwm_period_timer.sv
module pwm_period_timer #(
  parameter int unsigned TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic [TW-1:0] period_i,
  output logic [TW-1:0] tmr_o,
  output logic          match_o
);
  logic [TW-1:0] tmr_q;

  assign tmr_o   = tmr_q;
  assign match_o = tick_i && (tmr_q == period_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tmr_q <= '0;
    else if (tick_i) tmr_q <= match_o ? '0 : tmr_q + 1'b1;
  end

  AST_TMR_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(tmr_q)); // R9
  AST_RESTART_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |=> (tmr_q == '0)); // R1

endmodule

// File: rtl/pwm_duty_unit.sv
module pwm_duty_unit #(
  parameter int unsigned TW    = 8,
  parameter int unsigned SUB_W = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  run_i,
  input  logic                  pwm_en_i,
  input  logic                  start_i,
  input  logic [TW+SUB_W-1:0]   duty_i,
  input  logic [TW-1:0]         tmr_i,
  input  logic [SUB_W-1:0]      sub_i,
  output logic                  pwm_o
);
  localparam int unsigned DW = TW + SUB_W;

  logic [DW-1:0] act_q;
  logic [DW-1:0] pos;

  assign pos   = {tmr_i, sub_i};
  assign pwm_o = run_i && pwm_en_i && (pos < act_q);

  // the buffer follows the input while idle and is sampled at each restart
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             act_q <= '0;
    else if (!run_i || !pwm_en_i || start_i) act_q <= duty_i;
  end

  AST_ZERO_DUTY_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q == '0) |-> !pwm_o); // R3
  AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !pwm_o); // R9

endmodule

// File: rtl/pwm_irq_post.sv
module pwm_irq_post #(
  parameter int unsigned PSW = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic           match_i,
  input  logic [PSW-1:0] ratio_i,
  input  logic           clr_i,
  input  logic           ie_tmr_i,
  input  logic           ie_periph_i,
  input  logic           ie_global_i,
  output logic           flag_o,
  output logic           irq_o
);
  logic [PSW-1:0] cnt_q;
  logic           flag_q;
  logic           hit;

  assign hit    = match_i && (cnt_q >= ratio_i);
  assign flag_o = flag_q;
  assign irq_o  = flag_q && ie_tmr_i && ie_periph_i && ie_global_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!run_i)   cnt_q <= '0;
    else if (match_i)  cnt_q <= hit ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (hit)    flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  AST_FLAG_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(match_i)); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q); // R7
  AST_CNT_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0)); // R10

endmodule

// File: rtl/pwm_postscale_timer.sv
module pwm_postscale_timer #(
  parameter int unsigned TMR_W  = 8,
  parameter int unsigned SUB_W  = 2,
  parameter int unsigned PRE_SH = 4,
  parameter int unsigned POST_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tmr_on_i,
  input  logic [1:0]        pre_sel_i,
  input  logic [POST_W-1:0] post_div_i,
  input  logic [TMR_W-1:0]  period_i,
  input  logic [TMR_W-1:0]  duty_hi_i,
  input  logic [SUB_W-1:0]  duty_lo_i,
  input  logic [1:0]        mode_i,
  input  logic              ie_tmr_i,
  input  logic              ie_periph_i,
  input  logic              ie_global_i,
  input  logic              flag_clr_i,
  output logic              pwm_o,
  output logic              irq_o,
  output logic              flag_o
);
  import pwm_timer_pkg::*;

  localparam int unsigned PC_W = SUB_W + PRE_SH;

  logic             tick;
  logic [SUB_W-1:0] sub;
  logic [TMR_W-1:0] tmr;
  logic             match;
  logic             pwm_en;

  assign pwm_en = (mode_i == MODE_PWM);

  pwm_tick_gen #(.SUB_W(SUB_W), .PC_W(PC_W)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(tmr_on_i), .sel_i(pre_sel_i),
    .tick_o(tick), .sub_o(sub)
  );

  pwm_period_timer #(.TW(TMR_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(tmr_on_i), .tick_i(tick),
    .period_i(period_i), .tmr_o(tmr), .match_o(match)
  );

  pwm_duty_unit #(.TW(TMR_W), .SUB_W(SUB_W)) u_duty (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(tmr_on_i), .pwm_en_i(pwm_en),
    .start_i(match), .duty_i({duty_hi_i, duty_lo_i}), .tmr_i(tmr),
    .sub_i(sub), .pwm_o(pwm_o)
  );

  pwm_irq_post #(.PSW(POST_W)) u_post (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(tmr_on_i), .match_i(match),
    .ratio_i(post_div_i), .clr_i(flag_clr_i), .ie_tmr_i(ie_tmr_i),
    .ie_periph_i(ie_periph_i), .ie_global_i(ie_global_i),
    .flag_o(flag_o), .irq_o(irq_o)
  );

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flag_o && ie_global_i && ie_periph_i && ie_tmr_i)); // R8
  AST_MODE_OFF_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != MODE_PWM) |-> !pwm_o); // R5

endmodule

// File: tb/test_pwm_postscale_timer.sv
`timescale 1ns/1ps
module test_pwm_postscale_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ton = 1'b0;
  logic [1:0] pre = 2'b00;
  logic [3:0] post = 4'd0;
  logic [7:0] per = 8'd0;
  logic [7:0] dhi = 8'd0;
  logic [1:0] dlo = 2'd0;
  logic [1:0] mode = 2'b11;
  logic ie_t = 1'b0, ie_p = 1'b0, ie_g = 1'b0;
  logic clr = 1'b0;
  logic pwm, irq, flag;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwm_postscale_timer i_pwm_postscale_timer (
    .clk_i(clk), .rst_ni(rst_n), .tmr_on_i(ton), .pre_sel_i(pre),
    .post_div_i(post), .period_i(per), .duty_hi_i(dhi), .duty_lo_i(dlo),
    .mode_i(mode), .ie_tmr_i(ie_t), .ie_periph_i(ie_p), .ie_global_i(ie_g),
    .flag_clr_i(clr), .pwm_o(pwm), .irq_o(irq), .flag_o(flag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    ton = 1'b0; clr = 1'b0; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic set_duty(input int d);
    dhi = 8'(d >> 2);
    dlo = 2'(d & 3);
  endtask

  // one sample per clock state; entered right after a falling edge
  task automatic run_count(input int n, output int hi, output int first_flag);
    hi = 0; first_flag = -1;
    for (int k = 0; k < n; k++) begin
      #1;
      hi += int'(pwm);
      if (flag && first_flag < 0) first_flag = k;
      @(negedge clk);
    end
  endtask

  function automatic int pfac(input int code);
    return (code == 0) ? 1 : (code == 1) ? 4 : 16;
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int hi, ff, len, full, p;
    // R11 reset state
    ie_t = 1; ie_p = 1; ie_g = 1; set_duty(5); per = 8'd3;
    do_reset();
    #1;
    chk(pwm == 1'b0, "R11 pwm", int'(pwm), 0);
    chk(flag == 1'b0, "R11 flag", int'(flag), 0);
    chk(irq == 1'b0, "R11 irq", int'(irq), 0);
    ie_t = 0; ie_p = 0; ie_g = 0;

    // R1 R2 R3 sweep: every prescale code, small periods, duty 0..full+1
    for (int c = 0; c < 4; c++) begin
      for (int pr = 0; pr < 3; pr++) begin
        for (int d = 0; d <= 4 * (pr + 1) + 1; d++) begin
          p = pfac(c); full = 4 * (pr + 1); len = full * p;
          pre = 2'(c); per = 8'(pr); post = 4'd0; mode = 2'b11; set_duty(d);
          do_reset();
          @(negedge clk); ton = 1'b1;
          run_count(2 * len, hi, ff);
          chk(hi == 2 * ((d < full) ? d : full) * p, "R2/R3 high time", hi,
              2 * ((d < full) ? d : full) * p);
          chk(ff == len, "R1 period length", ff, len);
        end
      end
    end

    // R3 full duty with maximum code
    pre = 2'b01; per = 8'd3; set_duty(1023); do_reset();
    @(negedge clk); ton = 1'b1;
    run_count(64, hi, ff);
    chk(hi == 64, "R3 duty above period", hi, 64);

    // R4 duty rewritten while the pulse is high
    pre = 2'b00; per = 8'd3; set_duty(5); do_reset();
    @(negedge clk); ton = 1'b1;
    begin
      int h1 = 0, h2 = 0;
      for (int k = 0; k < 32; k++) begin
        #1;
        if (k < 16) h1 += int'(pwm); else h2 += int'(pwm);
        if (k == 2) set_duty(10);
        @(negedge clk);
      end
      chk(h1 == 5, "R4 current period keeps old duty", h1, 5);
      chk(h2 == 10, "R4 next period takes new duty", h2, 10);
    end

    // R5 non-PWM mode: output low, timer still runs
    mode = 2'b10; per = 8'd1; set_duty(6); do_reset();
    @(negedge clk); ton = 1'b1;
    run_count(16, hi, ff);
    chk(hi == 0, "R5 output low outside PWM mode", hi, 0);
    chk(ff == 8, "R5 timer runs outside PWM mode", ff, 8);
    mode = 2'b11;

    // R6 ratio 3, R7 sticky and clear, R8 gating
    per = 8'd1; post = 4'd2; set_duty(2); do_reset();
    @(negedge clk); ton = 1'b1;
    run_count(30, hi, ff);
    chk(ff == 24, "R6 flag after three matches", ff, 24);
    #1 chk(flag == 1'b1, "R7 flag held", int'(flag), 1);
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    #1 chk(flag == 1'b0, "R7 flag cleared by strobe", int'(flag), 0);
    @(negedge clk);
    run_count(19, hi, ff);
    chk(ff == 16, "R6 flag again after three more matches", ff, 16);
    for (int m = 0; m < 8; m++) begin
      @(negedge clk);
      ie_t = m[0]; ie_p = m[1]; ie_g = m[2];
      #1 chk(irq == (m == 7), "R8 irq gating", int'(irq), int'(m == 7));
    end
    @(negedge clk); clr = 1'b1; @(negedge clk); clr = 1'b0;
    #1 chk(irq == 1'b0, "R8 no irq without flag", int'(irq), 0);
    ie_t = 0; ie_p = 0; ie_g = 0;

    // R9 freeze mid-period
    per = 8'd3; post = 4'd0; set_duty(8); do_reset();
    @(negedge clk); ton = 1'b1;
    run_count(3, hi, ff);
    chk(hi == 3, "R9 before pause", hi, 3);
    ton = 1'b0;
    run_count(5, hi, ff);
    chk(hi == 0, "R9 output low while paused", hi, 0);
    ton = 1'b1;
    run_count(13, hi, ff);
    chk(hi == 5, "R9 period resumes where it stopped", hi, 5);
    #1 chk(pwm == 1'b1, "R9 next period starts high", int'(pwm), 1);

    // R10 postscale count cleared while paused
    per = 8'd3; post = 4'd1; set_duty(0); do_reset();
    @(negedge clk); ton = 1'b1;
    run_count(20, hi, ff);
    chk(ff == -1, "R10 no flag after one match", ff, -1);
    ton = 1'b0;
    run_count(3, hi, ff);
    ton = 1'b1;
    run_count(30, hi, ff);
    chk(ff == 28, "R10 count restarts after pause", ff, 28);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule